// File: doc/BRIEF.md
# ADC Conversion Step Sequencer with Dual Result Queues

This block drives a multiplexed analog-to-digital converter through a table of sixteen programmable steps. While the sequencer is running, it walks the enabled steps in ascending index order. For each step it presents that step's input select to the converter and waits the step's open delay. It then runs a power-of-two number of sample-and-convert rounds, each preceded by the step's sample delay. The summed samples are scaled down to a 12-bit average, and one result word, optionally tagged with the step index, is pushed into one of two result queues. The queue is chosen per step.

Software programs steps, enables, queue thresholds and interrupt enables through a simple write/read register port. Results are drained through two show-ahead pop ports. A sticky status vector records end-of-sequence and, for each queue, threshold, overrun and underflow events. A single interrupt line is raised when any status bit is set and enabled. A step can run once, repeat on every pass, or wait for an external trigger before it starts.

Top module: `adcseq_top`

## Requirements
- R1: After reset, the status vector is 0, irq is 0, conv_start is 0, and both queue counts (read at 0x06 and 0x07) are 0.
- R2: With run set (bit 0 of address 0x00), the enabled steps (mask at 0x01, bit n for step n) run in ascending index order and disabled steps are skipped. During each step, conv_chan equals that step's input select (bits 8:5 of the step word at 0x10+n).
- R3: The first conv_start of a pass begins open+sample+3 cycles after the clock edge that writes run. Within a step, each later conv_start comes sample+1 cycles after the cycle in which conv_done was high. Open is bits 17:0 and sample is bits 31:24 of the delay word at 0x20+n. conv_start lasts one cycle.
- R4: A step with averaging code c (bits 4:2 of its step word) issues 2^c conversions and stores (sum of samples) >> c. Codes 5 to 7 act as code 4.
- R5: A result word carries the average in bits 11:0. Bits 19:16 carry the step index when tagging (bit 1 of 0x00) is set, and are 0 otherwise. All other bits are 0. Bit 9 of the step word sends the word to queue 1 instead of queue 0.
- R6: The step mode is bits 1:0 of the step word. Mode 1 keeps the step enabled, so passes repeat. Mode 2 waits for hw_trig high before its open delay. Modes 0, 2 and 3 clear the step's enable bit once its result is written.
- R7: Status bit 1 is set after the last enabled step of a pass has written its result.
- R8: A push into a full queue (8 entries by default) drops the word and leaves the count and the stored words unchanged. It also sets status bit 3 for queue 0, or bit 6 for queue 1.
- R9: A pop from an empty queue returns 0 and sets status bit 4 for queue 0, or bit 7 for queue 1.
- R10: Status bit 2 (queue 0) or bit 5 (queue 1) is set while that queue's count is at least its nonzero threshold (0x04, 0x05). A zero threshold never sets it.
- R11: Status bits (read at 0x03) are sticky. Writing 1 to a bit at 0x03 clears it and leaves other bits untouched. irq is the OR of status ANDed with the enable mask at 0x02.
- R12: Each pop port shows the oldest word of its queue in the same cycle. Asserting pop removes that word, and words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| conv_start | output | 1 | One-cycle request to start a conversion |
| conv_chan | output | 4 | Input select of the active step |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 12 | Converter result |
| hw_trig | input | 1 | External start for trigger-mode steps |
| pop0 | input | 1 | Remove head of queue 0 |
| pop_data0 | output | 32 | Head word of queue 0 |
| pop1 | input | 1 | Remove head of queue 1 |
| pop_data1 | output | 32 | Head word of queue 1 |
| irq_status | output | 8 | Sticky event vector |
| irq | output | 1 | Enabled-event interrupt |

## Verification
The bench enables a sparse set of steps with step 0 disabled and compares the logged input selects and the queue contents against the expected order. A design that started at the wrong step or scanned the mask wrongly would log a different sequence of selects. It measures the exact cycle of the first start request and the gap after a conversion, which catches an off-by-one in either delay counter. It drives an averaging code of 7 with full-scale samples, which exposes a missing clamp: the accumulator would wrap and sixteen conversions would become 128. It fills a queue past capacity and drains it, showing that a design which overwrote on overrun would return the wrong words. It also checks that a pop from an empty queue yields zero, and that write-one-to-clear touches only the written bit.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int NSTEP   = 16;
    localparam int SW      = $clog2(NSTEP);
    localparam int DW      = 12;
    localparam int OPEN_W  = 18;
    localparam int SMP_W   = 8;
    localparam int AVG_MAX = 4;
    localparam int ACC_W   = DW + AVG_MAX;
    localparam int NCONV_W = AVG_MAX + 1;
    localparam int WORD_W  = 32;
    localparam int IRQ_W   = 8;
    localparam int TAG_LSB = 16;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_STEN = 8'h01;
    localparam logic [7:0] A_IREN = 8'h02;
    localparam logic [7:0] A_STAT = 8'h03;
    localparam logic [7:0] A_THR0 = 8'h04;
    localparam logic [7:0] A_THR1 = 8'h05;
    localparam logic [7:0] A_CNT0 = 8'h06;
    localparam logic [7:0] A_CNT1 = 8'h07;
    localparam logic [3:0] A_CFG_PAGE = 4'h1;
    localparam logic [3:0] A_DLY_PAGE = 4'h2;

    typedef enum logic [1:0] {
        STEP_ONESHOT = 2'd0,
        STEP_CONT    = 2'd1,
        STEP_HWSYNC  = 2'd2,
        STEP_RSVD    = 2'd3
    } step_mode_e;

    typedef struct packed {
        logic             to_q1;
        logic [3:0]       insel;
        logic [2:0]       avg;
        step_mode_e       mode;
    } step_cfg_t;

    typedef struct packed {
        logic [SMP_W-1:0]  samp;
        logic [OPEN_W-1:0] open;
    } step_dly_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_LOAD, SQ_HWWAIT, SQ_OPEN,
        SQ_SAMPLE, SQ_CONV, SQ_WRITE, SQ_EOS
    } seq_state_e;

    typedef struct packed {
        logic          valid;
        logic [SW-1:0] idx;
    } step_pick_t;

    // lowest enabled step whose index is at or above 'from'
    function automatic step_pick_t pick_step(input logic [NSTEP-1:0] mask,
                                             input logic [SW:0] from);
        step_pick_t r;
        r = '0;
        for (int i = NSTEP - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                r.valid = 1'b1;
                r.idx   = SW'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [2:0] eff_avg(input logic [2:0] code);
        return (code > 3'(AVG_MAX)) ? 3'(AVG_MAX) : code;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic [DW-1:0] d,
                                                    input logic [SW-1:0] tag,
                                                    input logic tag_en);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DW-1:0] = d;
        if (tag_en) w[TAG_LSB +: SW] = tag;
        return w;
    endfunction

endpackage

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          ovr,
    output logic          und
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovr     = push && full;
    assign und     = pop && empty;
    assign head    = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    p_ovr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == CW'(DEPTH)));
    p_und_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
    import adcseq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [7:0]                  wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic [7:0]                  rd_addr,
    output logic [31:0]                 rd_data,
    output logic                        run_o,
    output logic                        tag_o,
    output logic [NSTEP-1:0]            step_en_o,
    output step_cfg_t [NSTEP-1:0]       cfg_o,
    output step_dly_t [NSTEP-1:0]       dly_o,
    output logic [1:0][CNT_W-1:0]       thr_o,
    input  logic [1:0][CNT_W-1:0]       cnt_i,
    input  logic                        clr_valid_i,
    input  logic [SW-1:0]               clr_idx_i,
    input  logic [IRQ_W-1:0]            evt_i,
    output logic [IRQ_W-1:0]            stat_o,
    output logic                        irq_o
);
    logic [IRQ_W-1:0] irq_en_q;
    logic [IRQ_W-1:0] w1c;
    logic             wr_cfg, wr_dly, wr_sten, wr_stat;

    assign wr_cfg  = wr_en && (wr_addr[7:4] == A_CFG_PAGE);
    assign wr_dly  = wr_en && (wr_addr[7:4] == A_DLY_PAGE);
    assign wr_sten = wr_en && (wr_addr == A_STEN);
    assign wr_stat = wr_en && (wr_addr == A_STAT);
    assign w1c     = wr_stat ? wr_data[IRQ_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_o     <= 1'b0;
            tag_o     <= 1'b0;
            step_en_o <= '0;
            irq_en_q  <= '0;
            thr_o     <= '0;
            cfg_o     <= '0;
            dly_o     <= '0;
            stat_o    <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) {tag_o, run_o} <= wr_data[1:0];
            if (wr_sten)                    step_en_o <= wr_data[NSTEP-1:0];
            else if (clr_valid_i)           step_en_o[clr_idx_i] <= 1'b0;
            if (wr_en && wr_addr == A_IREN) irq_en_q <= wr_data[IRQ_W-1:0];
            if (wr_en && wr_addr == A_THR0) thr_o[0] <= wr_data[CNT_W-1:0];
            if (wr_en && wr_addr == A_THR1) thr_o[1] <= wr_data[CNT_W-1:0];
            if (wr_cfg) cfg_o[wr_addr[SW-1:0]] <= step_cfg_t'(wr_data[$bits(step_cfg_t)-1:0]);
            if (wr_dly) begin
                dly_o[wr_addr[SW-1:0]].samp <= wr_data[31:24];
                dly_o[wr_addr[SW-1:0]].open <= wr_data[OPEN_W-1:0];
            end
            // a new event in the same cycle wins over the clear
            stat_o <= (stat_o & ~w1c) | evt_i;
        end
    end

    assign irq_o = |(stat_o & irq_en_q);

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: rd_data = {30'b0, tag_o, run_o};
            A_STEN: rd_data = 32'(step_en_o);
            A_IREN: rd_data = 32'(irq_en_q);
            A_STAT: rd_data = 32'(stat_o);
            A_THR0: rd_data = 32'(thr_o[0]);
            A_THR1: rd_data = 32'(thr_o[1]);
            A_CNT0: rd_data = 32'(cnt_i[0]);
            A_CNT1: rd_data = 32'(cnt_i[1]);
            default: begin
                if (rd_addr[7:4] == A_CFG_PAGE)
                    rd_data = 32'(cfg_o[rd_addr[SW-1:0]]);
                else if (rd_addr[7:4] == A_DLY_PAGE)
                    rd_data = {dly_o[rd_addr[SW-1:0]].samp, 6'b0,
                               dly_o[rd_addr[SW-1:0]].open};
            end
        endcase
    end

    for (genvar k = 1; k < IRQ_W; k++) begin : g_stat_chk
        p_w1c_r11: assert property (@(posedge clk) disable iff (rst)
            (wr_stat && wr_data[k] && !evt_i[k]) |=> !stat_o[k]);
        p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
            (stat_o[k] && !(wr_stat && wr_data[k])) |=> stat_o[k]);
    end

    p_oneshot_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_valid_i && !wr_sten) |=> !step_en_o[$past(clr_idx_i)]);
endmodule

// File: rtl/adcseq_seq.sv
module adcseq_seq
    import adcseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  tag_en,
    input  logic [NSTEP-1:0]      step_en,
    input  step_cfg_t [NSTEP-1:0] cfg,
    input  step_dly_t [NSTEP-1:0] dly,
    input  logic                  hw_trig,
    input  logic                  conv_done,
    input  logic [DW-1:0]         conv_data,
    output logic                  conv_start,
    output logic [3:0]            conv_chan,
    output logic                  push0,
    output logic                  push1,
    output logic [WORD_W-1:0]     push_word,
    output logic                  clr_valid,
    output logic [SW-1:0]         clr_idx,
    output logic                  eos
);
    seq_state_e          state;
    logic [SW-1:0]       cur;
    step_cfg_t           cur_cfg;
    step_dly_t           cur_dly;
    logic [OPEN_W-1:0]   cnt;
    logic [ACC_W-1:0]    acc;
    logic [NCONV_W-1:0]  nconv, ns_tgt;
    logic [DW-1:0]       avg_res;
    step_pick_t          first_pick, next_pick;

    assign first_pick = pick_step(step_en, '0);
    assign next_pick  = pick_step(step_en, {1'b0, cur} + (SW+1)'(1));
    assign ns_tgt     = NCONV_W'(1) << eff_avg(cur_cfg.avg);
    assign avg_res    = DW'(acc >> eff_avg(cur_cfg.avg));

    assign conv_start = (state == SQ_SAMPLE) && (cnt == '0);
    assign conv_chan  = cur_cfg.insel;
    assign push0      = (state == SQ_WRITE) && !cur_cfg.to_q1;
    assign push1      = (state == SQ_WRITE) &&  cur_cfg.to_q1;
    assign push_word  = pack_word(avg_res, cur, tag_en);
    assign clr_valid  = (state == SQ_WRITE) && (cur_cfg.mode != STEP_CONT);
    assign clr_idx    = cur;
    assign eos        = (state == SQ_EOS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            cur     <= '0;
            cur_cfg <= '0;
            cur_dly <= '0;
            cnt     <= '0;
            acc     <= '0;
            nconv   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (run && first_pick.valid) begin
                        cur   <= first_pick.idx;
                        state <= SQ_LOAD;
                    end
                end
                SQ_LOAD: begin
                    cur_cfg <= cfg[cur];
                    cur_dly <= dly[cur];
                    cnt     <= dly[cur].open;
                    acc     <= '0;
                    nconv   <= '0;
                    state   <= (cfg[cur].mode == STEP_HWSYNC) ? SQ_HWWAIT : SQ_OPEN;
                end
                SQ_HWWAIT: begin
                    if (hw_trig) state <= SQ_OPEN;
                end
                SQ_OPEN: begin
                    if (cnt == '0) begin
                        cnt   <= OPEN_W'(cur_dly.samp);
                        state <= SQ_SAMPLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_SAMPLE: begin
                    if (cnt == '0) state <= SQ_CONV;
                    else           cnt   <= cnt - 1'b1;
                end
                SQ_CONV: begin
                    if (conv_done) begin
                        acc   <= acc + ACC_W'(conv_data);
                        nconv <= nconv + 1'b1;
                        if (nconv + 1'b1 == ns_tgt) begin
                            state <= SQ_WRITE;
                        end else begin
                            cnt   <= OPEN_W'(cur_dly.samp);
                            state <= SQ_SAMPLE;
                        end
                    end
                end
                SQ_WRITE: begin
                    if (next_pick.valid) begin
                        cur   <= next_pick.idx;
                        state <= SQ_LOAD;
                    end else begin
                        state <= SQ_EOS;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);
    p_chan_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_CONV && !conv_done) |=> $stable(conv_chan));
    p_push_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push0, push1}));
    p_conv_total_r4: assert property (@(posedge clk) disable iff (rst)
        (push0 || push1) |-> (nconv == ns_tgt));
    p_trig_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_HWWAIT && !hw_trig) |=> !conv_start);
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        conv_start,
    output logic [3:0]  conv_chan,
    input  logic        conv_done,
    input  logic [11:0] conv_data,
    input  logic        hw_trig,
    input  logic        pop0,
    output logic [31:0] pop_data0,
    input  logic        pop1,
    output logic [31:0] pop_data1,
    output logic [7:0]  irq_status,
    output logic        irq
);
    logic                    run, tag_en, eos, clr_valid;
    logic [SW-1:0]           clr_idx;
    logic [NSTEP-1:0]        step_en;
    step_cfg_t [NSTEP-1:0]   cfg;
    step_dly_t [NSTEP-1:0]   dly;
    logic [1:0][CNT_W-1:0]   thr, cnt;
    logic [1:0]              push_v, pop_v, ovr_v, und_v, thr_v;
    logic [1:0][WORD_W-1:0]  head_v;
    logic [WORD_W-1:0]       push_word;
    logic [IRQ_W-1:0]        evt;

    adcseq_regs #(.CNT_W(CNT_W)) regs_i (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .run_o(run), .tag_o(tag_en), .step_en_o(step_en),
        .cfg_o(cfg), .dly_o(dly), .thr_o(thr), .cnt_i(cnt),
        .clr_valid_i(clr_valid), .clr_idx_i(clr_idx),
        .evt_i(evt), .stat_o(irq_status), .irq_o(irq)
    );

    adcseq_seq seq_i (
        .clk, .rst, .run, .tag_en, .step_en, .cfg, .dly, .hw_trig,
        .conv_done, .conv_data, .conv_start, .conv_chan,
        .push0(push_v[0]), .push1(push_v[1]), .push_word,
        .clr_valid, .clr_idx, .eos
    );

    assign pop_v = {pop1, pop0};

    for (genvar g = 0; g < 2; g++) begin : g_q
        adcseq_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
            .clk, .rst,
            .push(push_v[g]), .push_data(push_word),
            .pop(pop_v[g]), .head(head_v[g]), .count(cnt[g]),
            .ovr(ovr_v[g]), .und(und_v[g])
        );
        assign thr_v[g] = (thr[g] != '0) && (cnt[g] >= thr[g]);
    end

    assign pop_data0 = head_v[0];
    assign pop_data1 = head_v[1];
    assign evt = {und_v[1], ovr_v[1], thr_v[1],
                  und_v[0], ovr_v[0], thr_v[0], eos, 1'b0};

    p_irq_source_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (irq_status != '0));
endmodule

// File: tb/adcseq_top_tb_top.sv
module adcseq_top_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 0, rst = 1;
    logic        wr_en = 0;
    logic [7:0]  wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic        conv_start, conv_done = 0, hw_trig = 0, pop0 = 0, pop1 = 0, irq;
    logic [3:0]  conv_chan;
    logic [11:0] conv_data = 0;
    logic [31:0] pop_data0, pop_data1;
    logic [7:0]  irq_status;

    int nvec = 0, nfail = 0;
    int gcnt = 0, g0 = 0, nstart = 0, ccnt = 0;
    int vbase = 0, vstep = 0;
    logic [3:0] chanlog [64];

    adcseq_top dut_i (.*);

    always #(CLK_P/2) clk = ~clk;

    // converter model: result 13 cycles after the start request
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (rst) ccnt <= 0;
        else if (conv_start) begin
            ccnt <= 13;
            chanlog[nstart & 63] <= conv_chan;
            nstart <= nstart + 1;
        end else if (ccnt != 0) begin
            ccnt <= ccnt - 1;
            if (ccnt == 1) begin
                conv_done <= 1'b1;
                conv_data <= 12'(vbase + (gcnt - g0) * vstep);
                gcnt <= gcnt + 1;
            end
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_addr = a; #1; d = rd_data;
    endtask

    task automatic popq(input bit q, output logic [31:0] d);
        @(negedge clk);
        if (q) pop1 = 1; else pop0 = 1;
        #1; d = q ? pop_data1 : pop_data0;
        @(posedge clk); #1; pop0 = 0; pop1 = 0;
    endtask

    task automatic setstep(input int n, input int mode, input int avg, input int insel,
                           input int q1, input int opn, input int smp);
        wr(8'h10 + 8'(n), 32'(mode) | (32'(avg) << 2) | (32'(insel) << 5) | (32'(q1) << 9));
        wr(8'h20 + 8'(n), 32'(opn) | (32'(smp) << 24));
    endtask

    task automatic wait_eos(input string rq);
        int k;
        for (k = 0; k < 5000 && !irq_status[1]; k++) @(negedge clk);
        chk(rq, "end of sequence seen", 32'(irq_status[1]), 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1", "status", 32'(irq_status), 0);
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "conv_start", 32'(conv_start), 0);
        rd(8'h06, d); chk("R1", "count0", d, 0);
        rd(8'h07, d); chk("R1", "count1", d, 0);
    endtask

    task automatic t_order;
        logic [31:0] d; int s0;
        wr(0, 0); wr(3, 32'hFF);
        setstep(1, 0, 0, 5, 0, 1, 0);
        setstep(3, 0, 0, 9, 1, 1, 0);
        setstep(6, 0, 0, 2, 0, 1, 0);
        vbase = 200; vstep = 10; g0 = gcnt; s0 = nstart;
        wr(1, 32'h004A); wr(0, 3);
        wait_eos("R7");
        chk("R2", "conversions", 32'(nstart - s0), 3);
        chk("R2", "select 1st", 32'(chanlog[s0 & 63]), 5);
        chk("R2", "select 2nd", 32'(chanlog[(s0 + 1) & 63]), 9);
        chk("R2", "select 3rd", 32'(chanlog[(s0 + 2) & 63]), 2);
        rd(8'h06, d); chk("R5", "count0", d, 2);
        rd(8'h07, d); chk("R5", "count1", d, 1);
        chk("R10", "zero threshold idle", 32'(irq_status[2]), 0);
        popq(0, d); chk("R12", "q0 first word", d, (32'd1 << 16) | 200);
        popq(0, d); chk("R12", "q0 second word", d, (32'd6 << 16) | 220);
        popq(1, d); chk("R5", "q1 word", d, (32'd3 << 16) | 210);
        rd(8'h01, d); chk("R6", "one-shot enables cleared", d, 0);
    endtask

    task automatic t_timing;
        logic [31:0] d; int n, m;
        wr(0, 0); wr(3, 32'hFF);
        setstep(0, 0, 1, 3, 0, 5, 2);
        vbase = 1000; vstep = 2; g0 = gcnt;
        wr(1, 1); wr(0, 1);
        n = 0;
        while (!conv_start && n < 100) begin @(posedge clk); @(negedge clk); n++; end
        chk("R3", "first start delay", 32'(n), 10);
        while (!conv_done) @(negedge clk);
        m = 0;
        while (!conv_start && m < 100) begin @(posedge clk); @(negedge clk); m++; end
        chk("R3", "done to next start", 32'(m), 3);
        wait_eos("R3");
        popq(0, d); chk("R4", "two-sample average", d, 1001);
    endtask

    task automatic t_average;
        logic [31:0] d; int s0;
        wr(0, 0); wr(3, 32'hFF);
        setstep(2, 0, 2, 1, 0, 0, 0);
        vbase = 100; vstep = 3; g0 = gcnt; s0 = nstart;
        wr(1, 4); wr(0, 1);
        wait_eos("R4");
        chk("R4", "code 2 conversions", 32'(nstart - s0), 4);
        popq(0, d); chk("R4", "code 2 average", d, 104);
        wr(3, 32'hFF);
        setstep(2, 0, 7, 1, 0, 0, 0);
        vbase = 4095; vstep = 0; g0 = gcnt; s0 = nstart;
        wr(1, 4);
        wait_eos("R4");
        chk("R4", "code 7 clamps to 16", 32'(nstart - s0), 16);
        popq(0, d); chk("R5", "full-scale untagged word", d, 4095);
    endtask

    task automatic t_hwsync;
        logic [31:0] d; int s0;
        wr(0, 0); wr(3, 32'hFF);
        setstep(4, 2, 0, 7, 1, 0, 0);
        vbase = 55; vstep = 0; g0 = gcnt; s0 = nstart; hw_trig = 0;
        wr(1, 16); wr(0, 3);
        repeat (60) @(negedge clk);
        chk("R6", "no start before trigger", 32'(nstart - s0), 0);
        chk("R6", "no eos before trigger", 32'(irq_status[1]), 0);
        @(negedge clk); hw_trig = 1; @(negedge clk); hw_trig = 0;
        wait_eos("R6");
        popq(1, d); chk("R6", "triggered result", d, (32'd4 << 16) | 55);
        rd(8'h01, d); chk("R6", "trigger step cleared", d, 0);
    endtask

    task automatic t_continuous;
        logic [31:0] d, c; int k;
        wr(0, 0); wr(3, 32'hFF);
        setstep(5, 1, 0, 3, 0, 0, 0);
        vbase = 7; vstep = 1; g0 = gcnt;
        wr(1, 32); wr(0, 1);
        c = 0;
        for (k = 0; k < 2000 && c < 3; k++) rd(8'h06, c);
        rd(8'h01, d); chk("R6", "continuous step stays enabled", d, 32);
        wr(1, 0);
        repeat (100) @(negedge clk);
        rd(8'h06, c);
        chk("R6", "passes repeated", 32'(c >= 3), 1);
        for (int i = 0; i < int'(c); i++) begin
            popq(0, d); chk("R12", "drain order", d, 32'(7 + i));
        end
    endtask

    task automatic t_overrun;
        logic [31:0] d; int k;
        wr(0, 0); wr(3, 32'hFF); wr(4, 3);
        setstep(0, 1, 0, 0, 0, 0, 0);
        vbase = 300; vstep = 1; g0 = gcnt;
        wr(1, 1); wr(0, 1);
        for (k = 0; k < 3000 && !irq_status[3]; k++) @(negedge clk);
        wr(1, 0);
        repeat (100) @(negedge clk);
        rd(8'h06, d); chk("R8", "count at full", d, 8);
        chk("R8", "overrun flag", 32'(irq_status[3]), 1);
        chk("R10", "threshold flag", 32'(irq_status[2]), 1);
        for (int i = 0; i < 8; i++) begin
            popq(0, d); chk("R8", "kept words", d, 32'(300 + i));
        end
        wr(3, 32'hFF);
        popq(0, d); chk("R9", "empty pop q0 data", d, 0);
        chk("R9", "underflow q0", 32'(irq_status[4]), 1);
        popq(1, d); chk("R9", "empty pop q1 data", d, 0);
        chk("R9", "underflow q1", 32'(irq_status[7]), 1);
    endtask

    task automatic t_irq;
        wr(2, 0);
        chk("R11", "masked irq", 32'(irq), 0);
        wr(2, 32'h10);
        chk("R11", "enabled irq", 32'(irq), 1);
        wr(3, 32'h10);
        chk("R11", "w1c bit4", 32'(irq_status[4]), 0);
        chk("R11", "w1c leaves bit7", 32'(irq_status[7]), 1);
        chk("R11", "irq after clear", 32'(irq), 0);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_order();
        t_timing();
        t_average();
        t_hwsync();
        t_continuous();
        t_overrun();
        t_irq();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nvec++; nfail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end
endmodule